// File: doc/BRIEF.md
# DIMM thermal sensor poller

This block reads the temperature register of every fitted DIMM thermal sensor on its own, through the shared SMBus command engine, so that closed-loop thermal throttling keeps working without software involvement. An interval input turns polling on: zero means off, and any other value sets the time between polling rounds, counted in prescaled ticks. An 8-bit presence mask says which of the eight sensor addresses are fitted. Polling also stops while the engine reports its sticky bus error.

Within a round the poller walks the slots from 0 upward. It issues one word read at a time to each present sensor and waits for that read to complete before it issues the next. The engine returns the two bytes in arrival order. The poller stores them with the first byte as the most significant one, in a small per-slot register array that has a valid bit for each slot.

Software reaches the same engine through an arbiter. Software is granted the engine as soon as no automatic read is outstanding. While software holds the engine, the poller stays paused at its current slot. Software normally also writes zero to the interval for the duration of its own access, then restores the interval.

Top module: `dimm_thermal_poller`

## Requirements
- R1: When interval_i is zero, no automatic read is started. When interval_i is nonzero and nothing else blocks it, polling rounds run.
- R2: While eng_sberr_i is high, no automatic read is started.
- R3: A round visits only slots whose present_i bit n is 1, at bus address 0x18 + n, in ascending n. Only one transaction is outstanding at a time: a new start comes only after eng_done_i for the previous one.
- R4: Every automatic read has eng_word_o = 1, eng_write_o = 0 and eng_reg_o = TEMP_REG (default 8'h05).
- R5: The engine returns the first received byte in eng_rdata_i[7:0] and the second in [15:8]. After a read without error, the slot holds {first, second} and its valid bit is 1.
- R6: A read that completes with eng_err_i = 1 clears the slot's valid bit and leaves its stored value unchanged.
- R7: When a round finishes within the interval, consecutive rounds start exactly interval_i × TICK_DIV clock cycles apart.
- R8: sw_gnt_o is 1 only when sw_req_i is 1 and no automatic read is outstanding. While it is 1, the engine outputs follow the sw_* inputs and the poller starts nothing. When the grant ends, polling resumes at the slot where it paused.
- R9: After reset, every slot reads as not valid, and eng_start_o and sw_gnt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| interval_i | input | IVL_W | Ticks between rounds; 0 disables polling |
| present_i | input | NSLOT | Sensor fitted per slot |
| eng_sberr_i | input | 1 | Engine sticky bus error flag |
| sw_req_i | input | 1 | Software requests the engine |
| sw_gnt_o | output | 1 | Engine granted to software |
| sw_start_i | input | 1 | Software command start pulse |
| sw_addr_i | input | 7 | Software bus address |
| sw_reg_i | input | 8 | Software register address |
| sw_word_i | input | 1 | Software word access |
| sw_write_i | input | 1 | Software write access |
| sw_wdata_i | input | 16 | Software write data |
| eng_start_o | output | 1 | Engine command start pulse |
| eng_addr_o | output | 7 | Engine bus address |
| eng_reg_o | output | 8 | Engine register address |
| eng_word_o | output | 1 | Engine word access |
| eng_write_o | output | 1 | Engine write access |
| eng_wdata_o | output | 16 | Engine write data |
| eng_done_i | input | 1 | Engine transaction complete pulse |
| eng_err_i | input | 1 | Engine transaction error, valid with done |
| eng_rdata_i | input | 16 | Engine read data, first byte in [7:0] |
| rd_slot_i | input | SLOT_W | Slot selected for readout |
| rd_temp_o | output | 16 | Stored temperature of the selected slot |
| rd_valid_o | output | 1 | Valid bit of the selected slot |

## Verification
The sparse mask 8'hA5 shows that absent slots are skipped and that the order is ascending. It also shows whether each slot's address is derived correctly. A second round with an error injected on one slot separates error handling (valid cleared, value kept) from normal updates, because the other slots change their data. A single-sensor mask with a fixed interval makes the round period measurable cycle for cycle. A full mask with slow engine responses and a software request raised mid-transaction shows whether the grant waits for completion and whether polling later resumes from the paused slot rather than from slot 0. Running with the interval at zero and with the sticky error set separates the two gating conditions.

// File: rtl/dimm_thermal_poller.sv
module dimm_thermal_poller #(
  parameter int         TICK_DIV  = 4,
  parameter int         IVL_W     = 16,
  parameter int         NSLOT     = 8,
  parameter logic [6:0] BASE_ADDR = 7'h18,
  parameter logic [7:0] TEMP_REG  = 8'h05,
  localparam int        SLOT_W    = $clog2(NSLOT),
  localparam int        PW        = $clog2(TICK_DIV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  interval_i,
  input  logic [NSLOT-1:0]  present_i,
  input  logic              eng_sberr_i,
  input  logic              sw_req_i,
  output logic              sw_gnt_o,
  input  logic              sw_start_i,
  input  logic [6:0]        sw_addr_i,
  input  logic [7:0]        sw_reg_i,
  input  logic              sw_word_i,
  input  logic              sw_write_i,
  input  logic [15:0]       sw_wdata_i,
  output logic              eng_start_o,
  output logic [6:0]        eng_addr_o,
  output logic [7:0]        eng_reg_o,
  output logic              eng_word_o,
  output logic              eng_write_o,
  output logic [15:0]       eng_wdata_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic [15:0]       eng_rdata_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [15:0]       rd_temp_o,
  output logic              rd_valid_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WAIT} st_t;

  st_t               state_q;
  logic [PW-1:0]     presc_q;
  logic [IVL_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] ptr_q;
  logic              start_q;
  logic [15:0]       temp_q [NSLOT];
  logic [NSLOT-1:0]  valid_q;

  wire tick     = presc_q == PW'(TICK_DIV - 1);
  wire go       = (interval_i != '0) && !eng_sberr_i && !sw_req_i;
  wire expire   = (cnt_q == '0) || (cnt_q == IVL_W'(1) && tick);
  wire round_go = (state_q == ST_IDLE) && expire && go;
  wire issue    = (state_q == ST_SCAN) && present_i[ptr_q] && go;
  wire last     = ptr_q == SLOT_W'(NSLOT - 1);

  assign sw_gnt_o    = sw_req_i && (state_q != ST_WAIT);
  assign eng_start_o = sw_gnt_o ? sw_start_i : start_q;
  assign eng_addr_o  = sw_gnt_o ? sw_addr_i  : BASE_ADDR + 7'(ptr_q);
  assign eng_reg_o   = sw_gnt_o ? sw_reg_i   : TEMP_REG;
  assign eng_word_o  = sw_gnt_o ? sw_word_i  : 1'b1;
  assign eng_write_o = sw_gnt_o ? sw_write_i : 1'b0;
  assign eng_wdata_o = sw_gnt_o ? sw_wdata_i : 16'h0000;
  assign rd_temp_o   = temp_q[rd_slot_i];
  assign rd_valid_o  = valid_q[rd_slot_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      presc_q <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      start_q <= 1'b0;
      valid_q <= '0;
      for (int i = 0; i < NSLOT; i++) temp_q[i] <= '0;
    end else begin
      start_q <= issue;
      presc_q <= (round_go || tick) ? '0 : presc_q + PW'(1);
      if (round_go)                  cnt_q <= interval_i;
      else if (tick && cnt_q != '0)  cnt_q <= cnt_q - IVL_W'(1);
      case (state_q)
        ST_IDLE: if (round_go) begin
          state_q <= ST_SCAN;
          ptr_q   <= '0;
        end
        ST_SCAN: begin
          if (issue) state_q <= ST_WAIT;
          else if (!present_i[ptr_q]) begin
            if (last) state_q <= ST_IDLE;
            else      ptr_q   <= ptr_q + SLOT_W'(1);
          end
        end
        ST_WAIT: if (eng_done_i) begin
          if (eng_err_i) valid_q[ptr_q] <= 1'b0;
          else begin
            valid_q[ptr_q] <= 1'b1;
            temp_q[ptr_q]  <= {eng_rdata_i[7:0], eng_rdata_i[15:8]};
          end
          if (last) state_q <= ST_IDLE;
          else begin
            ptr_q   <= ptr_q + SLOT_W'(1);
            state_q <= ST_SCAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(interval_i) != '0);

  a_r2_no_start_on_sberr: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !$past(eng_sberr_i));

  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !eng_done_i) |=> !start_q);

  a_r3_present_only: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(present_i[ptr_q]));

  a_r4_word_read: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !sw_gnt_o) |-> (eng_word_o && !eng_write_o && eng_reg_o == TEMP_REG));

  a_r5_valid_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && eng_done_i && !eng_err_i) |=> valid_q[$past(ptr_q)]);

  a_r6_err_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && eng_done_i && eng_err_i) |=>
      (!valid_q[$past(ptr_q)] && temp_q[$past(ptr_q)] == $past(temp_q[ptr_q])));

  a_r8_no_auto_while_granted: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_gnt_o) |-> !start_q);

endmodule

// File: tb/tb_dimm_thermal_poller.sv
module tb_dimm_thermal_poller;
  localparam int D = 4;

  logic clk = 0, rst_n = 0;
  logic [15:0] interval_i = 0;
  logic [7:0]  present_i = 0;
  logic eng_sberr_i = 0, sw_req_i = 0, sw_start_i = 0, sw_word_i = 0, sw_write_i = 0;
  logic [6:0]  sw_addr_i = 0;
  logic [7:0]  sw_reg_i = 0;
  logic [15:0] sw_wdata_i = 0;
  logic eng_done_i = 0, eng_err_i = 0;
  logic [15:0] eng_rdata_i = 0;
  logic [2:0]  rd_slot_i = 0;
  logic sw_gnt_o, eng_start_o, eng_word_o, eng_write_o, rd_valid_o;
  logic [6:0]  eng_addr_o;
  logic [7:0]  eng_reg_o;
  logic [15:0] eng_wdata_o, rd_temp_o;

  dimm_thermal_poller #(.TICK_DIV(D)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, starts = 0, cyc = 0, lat = 3;
  logic [7:0] err_mask = 0, salt = 0;
  logic [6:0] expq[$];
  int times[$];
  bit busy = 0;

  function automatic logic [7:0] b_first(input logic [2:0] s, input logic [7:0] sl);
    return 8'h30 + {5'd0, s} + sl;
  endfunction
  function automatic logic [7:0] b_second(input logic [2:0] s);
    return 8'hA0 | {5'd0, s};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic slot(input string tag, input int s, input logic [15:0] t, input logic v, input bit cmp_t);
    rd_slot_i = 3'(s);
    #1;
    chk({tag, " valid"}, {31'd0, rd_valid_o}, {31'd0, v});
    if (cmp_t) chk({tag, " temp"}, {16'd0, rd_temp_o}, {16'd0, t});
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
  endtask

  initial forever begin @(posedge clk); cyc++; end

  // engine model
  initial forever begin
    @(negedge clk);
    if (eng_start_o) begin
      logic [2:0] s;
      s = eng_addr_o[2:0];
      repeat (lat) @(posedge clk);
      eng_done_i  <= 1'b1;
      eng_err_i   <= err_mask[s];
      eng_rdata_i <= {b_second(s), b_first(s, salt)};
      @(posedge clk);
      eng_done_i <= 1'b0;
      eng_err_i  <= 1'b0;
    end
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (eng_done_i) busy = 0;
    if (eng_start_o) begin
      if (busy) begin fails++; checks++; $display("FAIL R3 start while busy act=%0h exp=none", eng_addr_o); end
      busy = 1;
      if (!sw_gnt_o) begin
        starts++;
        times.push_back(cyc);
        if (expq.size() == 0) begin
          fails++; checks++;
          $display("FAIL R1/R2 unexpected auto read act=%0h exp=none", eng_addr_o);
        end else begin
          logic [6:0] e;
          e = expq.pop_front();
          chk("R3 address order", {25'd0, eng_addr_o}, {25'd0, e});
          chk("R4 word read of temp reg", {22'd0, eng_word_o, eng_write_o, eng_reg_o}, {22'd0, 1'b1, 1'b0, 8'h05});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    for (int s = 0; s < 8; s++) slot("R9 reset", s, 16'h0, 1'b0, 1'b0);
    chk("R9 start idle", {31'd0, eng_start_o}, 0);
    chk("R9 grant idle", {31'd0, sw_gnt_o}, 0);

    // R1 interval zero: nothing starts
    present_i = 8'hFF;
    repeat (60) @(negedge clk);
    chk("R1 off no starts", starts, 0);

    // R3/R5 sparse mask round
    present_i = 8'hA5; salt = 0;
    expq = '{7'h18, 7'h1A, 7'h1D, 7'h1F};
    interval_i = 3;
    drain();
    interval_i = 0;
    repeat (20) @(negedge clk);
    chk("R1 enabled round count", starts, 4);
    foreach (expq[i]) ;
    for (int s = 0; s < 8; s++) begin
      if (present_i[s]) slot("R5 stored", s, {b_first(3'(s), 0), b_second(3'(s))}, 1'b1, 1'b1);
    end
    slot("R3 absent slot1", 1, 16'h0, 1'b0, 1'b0);
    slot("R3 absent slot6", 6, 16'h0, 1'b0, 1'b0);

    // R6 error on slot 2
    err_mask = 8'h04; salt = 8'h01;
    expq = '{7'h18, 7'h1A, 7'h1D, 7'h1F};
    interval_i = 3;
    drain();
    interval_i = 0;
    repeat (20) @(negedge clk);
    slot("R6 errored slot2", 2, {b_first(3'd2, 0), b_second(3'd2)}, 1'b0, 1'b1);
    slot("R5 updated slot0", 0, {b_first(3'd0, 8'h01), b_second(3'd0)}, 1'b1, 1'b1);
    slot("R5 updated slot7", 7, {b_first(3'd7, 8'h01), b_second(3'd7)}, 1'b1, 1'b1);
    err_mask = 0;

    // R2 sticky error blocks polling
    starts = 0;
    eng_sberr_i = 1; interval_i = 2;
    repeat (60) @(negedge clk);
    chk("R2 sberr no starts", starts, 0);
    interval_i = 0;
    @(negedge clk);
    eng_sberr_i = 0;

    // R7 round period
    present_i = 8'h01;
    times.delete();
    expq = '{7'h18, 7'h18, 7'h18};
    interval_i = 5;
    drain();
    interval_i = 0;
    repeat (30) @(negedge clk);
    chk("R7 period a", times[1] - times[0], 5 * D);
    chk("R7 period b", times[2] - times[1], 5 * D);

    // R8 arbitration
    present_i = 8'hFF; lat = 10;
    expq = '{7'h18};
    interval_i = 1;
    drain();
    @(negedge clk);
    sw_req_i = 1;
    @(negedge clk);
    chk("R8 no grant in flight", {31'd0, sw_gnt_o}, 0);
    while (!eng_done_i) @(negedge clk);
    chk("R8 no grant at done", {31'd0, sw_gnt_o}, 0);
    @(negedge clk);
    chk("R8 grant after done", {31'd0, sw_gnt_o}, 1);
    sw_start_i = 1; sw_addr_i = 7'h50; sw_reg_i = 8'h07; sw_write_i = 1; sw_wdata_i = 16'hBEEF;
    #1;
    chk("R8 sw passthrough", {eng_start_o, eng_addr_o, eng_write_o, eng_wdata_o}, {1'b1, 7'h50, 1'b1, 16'hBEEF});
    @(negedge clk);
    sw_start_i = 0;
    repeat (40) @(negedge clk);
    interval_i = 0;
    @(negedge clk);
    sw_req_i = 0;
    lat = 3;
    expq = '{7'h19, 7'h1A, 7'h1B, 7'h1C, 7'h1D, 7'h1E, 7'h1F};
    interval_i = 1;
    drain();
    interval_i = 0;
    repeat (20) @(negedge clk);
    slot("R8 resumed slot1", 1, {b_first(3'd1, 8'h01), b_second(3'd1)}, 1'b1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule